// File: doc/BRIEF.md
# Multichannel Stream Sample Width Upscaler

This block sits between a converter's sample capture logic and a wide stream consumer. Each input beat carries several channels packed side by side. Each channel occupies a narrow field of 12, 14, 16 or 18 bits. The block widens every channel field into a power-of-two lane by placing zeros above the sample, and it sends the packed result on an output stream. Sign extension is not performed. Both streams use valid/ready handshakes, and the block keeps full backpressure between them.

The converter can run in a mode where the sample is two bits narrower than the configured field. A static control input selects that mode. When the control is high, each field is moved down by two bit positions before it is padded. The control is captured together with the beat it applies to. A change to the control therefore never alters a beat that the block already holds.

The output is a single register stage. The input is ready whenever that stage is empty or is being emptied in the same cycle, so the block can move one beat per clock.

Top module: `stream_upscaler`

## Requirements
- R1: After a cycle with `rst` high, `out_valid` is low and `in_ready` is high.
- R2: With `shift_en` low at acceptance, output lane c (bits `[c*LANE_W +: LANE_W]`) equals input field c (bits `[c*SAMP_W +: SAMP_W]`), zero-extended to the lane width.
- R3: By default the lane width is 32 when the sample width exceeds 16, and 16 otherwise. For an 18-bit sample on two channels, the output bus is 64 bits wide.
- R4: With `shift_en` high at acceptance, output lane c equals input field c shifted right by two positions, with zeros filling the upper bits, and then zero-extended to the lane width.
- R5: `shift_en` is sampled at the input handshake. Changing it while a beat is held does not change that beat.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change on the next cycle.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A beat can be accepted in the same cycle that the held beat leaves.
- R8: Every accepted beat appears on the output exactly once, in acceptance order. A beat transfers only when both valid and ready are high. After a drain with no new input, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Narrow-sample mode: shift each field down two bits |
| in_data | input | N_CH*SAMP_W | Packed input channel fields |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| out_data | output | N_CH*LANE_W | Packed widened lanes |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |

## Verification
The hardest case to reach is a beat held under backpressure while `shift_en` flips. This must be combined with a new input that is accepted in the very cycle the held beat drains. Here any mix-up between capture-time and current-time control values, or any dropped or duplicated beat, becomes visible. Random stimulus toggles `out_ready`, `in_valid` and `shift_en` on every cycle, with a biased ready probability, so that holds and same-cycle refills occur often. Directed sequences add a forced hold with a control flip, and all-ones fields that expose the exact shift and padding boundaries.

// File: rtl/upscale_pkg.sv
package upscale_pkg;

    // Number of bits dropped in narrow-sample mode
    localparam int unsigned SHIFT_BITS = 2;

    // Power-of-two lane that holds a sample of the given width
    function automatic int unsigned lane_width_for(input int unsigned samp_w);
        return (samp_w > 16) ? 32 : 16;
    endfunction

endpackage

// File: rtl/upscale_lane.sv
module upscale_lane #(
    parameter int unsigned SAMP_W = 16,
    parameter int unsigned LANE_W = 16
) (
    input  logic [SAMP_W-1:0] field,
    input  logic              shift,
    output logic [LANE_W-1:0] lane
);
    logic [SAMP_W-1:0] aligned;

    always_comb begin
        if (shift) begin
            aligned = field >> upscale_pkg::SHIFT_BITS;
        end else begin
            aligned = field;
        end
    end

    generate
        if (LANE_W > SAMP_W) begin : g_pad
            assign lane = {{(LANE_W-SAMP_W){1'b0}}, aligned};
        end else begin : g_same
            assign lane = aligned[LANE_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/upscale_widen.sv
module upscale_widen #(
    parameter int unsigned N_CH   = 2,
    parameter int unsigned SAMP_W = 16,
    parameter int unsigned LANE_W = 16,
    localparam int unsigned IN_W  = N_CH*SAMP_W,
    localparam int unsigned OUT_W = N_CH*LANE_W
) (
    input  logic [IN_W-1:0]  packed_in,
    input  logic             shift,
    output logic [OUT_W-1:0] packed_out
);
    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            upscale_lane #(
                .SAMP_W(SAMP_W),
                .LANE_W(LANE_W)
            ) u_lane (
                .field(packed_in[c*SAMP_W +: SAMP_W]),
                .shift(shift),
                .lane (packed_out[c*LANE_W +: LANE_W])
            );
        end
    endgenerate
endmodule

// File: rtl/upscale_outreg.sv
module upscale_outreg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic         d_valid,
    output logic         d_ready,
    output logic [W-1:0] q,
    output logic         q_valid,
    input  logic         q_ready
);
    logic take;

    assign d_ready = !q_valid || q_ready;
    assign take    = d_valid && d_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
        end else if (take) begin
            q_valid <= 1'b1;
        end else if (q_ready) begin
            q_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (take) begin
            q <= d;
        end
    end
endmodule

// File: rtl/stream_upscaler.sv
module stream_upscaler #(
    parameter int unsigned N_CH   = 2,
    parameter int unsigned SAMP_W = 16,
    parameter int unsigned LANE_W = upscale_pkg::lane_width_for(SAMP_W),
    localparam int unsigned IN_W  = N_CH*SAMP_W,
    localparam int unsigned OUT_W = N_CH*LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready
);
    logic [OUT_W-1:0] widened;

    upscale_widen #(
        .N_CH  (N_CH),
        .SAMP_W(SAMP_W),
        .LANE_W(LANE_W)
    ) u_widen (
        .packed_in (in_data),
        .shift     (shift_en),
        .packed_out(widened)
    );

    upscale_outreg #(
        .W(OUT_W)
    ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .d      (widened),
        .d_valid(in_valid),
        .d_ready(in_ready),
        .q      (out_data),
        .q_valid(out_valid),
        .q_ready(out_ready)
    );
endmodule

// File: rtl/stream_upscaler_chk.sv
module stream_upscaler_chk #(
    parameter int unsigned N_CH   = 2,
    parameter int unsigned SAMP_W = 16,
    parameter int unsigned LANE_W = 16,
    localparam int unsigned OUT_W = N_CH*LANE_W
) (
    input logic             clk,
    input logic             rst,
    input logic             shift_en,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_ready
);
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    p_open_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid || out_ready |-> in_ready);

    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    p_drain_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid |=> !out_valid);

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ck
            if (LANE_W > SAMP_W) begin : g_pad
                p_pad_r2: assert property (@(posedge clk) disable iff (rst)
                    out_valid |-> out_data[c*LANE_W+SAMP_W +: LANE_W-SAMP_W] == '0);
            end
            p_shift_top_r4: assert property (@(posedge clk) disable iff (rst)
                in_valid && in_ready && shift_en |=>
                    out_data[c*LANE_W+SAMP_W-2 +: 2] == 2'b00);
        end
    endgenerate
endmodule

bind stream_upscaler stream_upscaler_chk #(
    .N_CH  (N_CH),
    .SAMP_W(SAMP_W),
    .LANE_W(LANE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready)
);

// File: tb/test_stream_upscaler.sv
module test_stream_upscaler;
    localparam int unsigned NC = 2;
    localparam int unsigned SW = 16;
    localparam int unsigned LW = 16;
    localparam int unsigned IW = NC*SW;
    localparam int unsigned OW = NC*LW;
    localparam int unsigned WSW = 18;
    localparam int unsigned WLW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          shift_en = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
    logic [IW-1:0] in_data = '0;
    logic          in_ready, out_valid;
    logic [OW-1:0] out_data;

    stream_upscaler #(.N_CH(NC), .SAMP_W(SW)) i_stream_upscaler (
        .clk(clk), .rst(rst), .shift_en(shift_en), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready));

    logic              w_shift = 1'b0, w_in_valid = 1'b0, w_out_ready = 1'b0;
    logic [NC*WSW-1:0] w_in_data = '0;
    logic              w_in_ready, w_out_valid;
    logic [NC*WLW-1:0] w_out_data;

    stream_upscaler #(.N_CH(NC), .SAMP_W(WSW)) i_stream_upscaler_wide (
        .clk(clk), .rst(rst), .shift_en(w_shift), .in_data(w_in_data),
        .in_valid(w_in_valid), .in_ready(w_in_ready), .out_data(w_out_data),
        .out_valid(w_out_valid), .out_ready(w_out_ready));

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [OW-1:0] exp_q[$];
    logic          hold_pend = 1'b0;
    logic [OW-1:0] hold_val = '0;

    function automatic logic [OW-1:0] exp_main(logic [IW-1:0] d, logic s);
        logic [OW-1:0] r = '0;
        for (int c = 0; c < NC; c++) begin
            logic [SW-1:0] f = d[c*SW +: SW];
            if (s) f = f >> 2;
            r[c*LW +: LW] = LW'(f);
        end
        return r;
    endfunction

    function automatic logic [NC*WLW-1:0] exp_wide(logic [NC*WSW-1:0] d, logic s);
        logic [NC*WLW-1:0] r = '0;
        for (int c = 0; c < NC; c++) begin
            logic [WSW-1:0] f = d[c*WSW +: WSW];
            if (s) f = f >> 2;
            r[c*WLW +: WLW] = WLW'(f);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, then score what the coming edge will do
    task automatic step(input logic iv, input logic [IW-1:0] d, input logic sh,
                        input logic ordy);
        @(negedge clk);
        in_valid = iv; in_data = d; shift_en = sh; out_ready = ordy;
        #1;
        if (hold_pend) begin
            chk(out_valid && out_data == hold_val, "R6 hold",
                64'(out_data), 64'(hold_val));
        end
        chk(in_ready == (!out_valid || out_ready), "R7 ready",
            64'(in_ready), 64'(!out_valid || out_ready));
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected beat", 64'(out_data), 64'd0);
            end else begin
                logic [OW-1:0] e = exp_q.pop_front();
                chk(out_data == e, "R8 R2/R4 data", 64'(out_data), 64'(e));
            end
        end
        hold_pend = out_valid && !out_ready;
        hold_val  = out_data;
        if (in_valid && in_ready) exp_q.push_back(exp_main(d, sh));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(!out_valid, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(in_ready, "R1 in_ready", 64'(in_ready), 64'd1);

        // R2 and R4 boundaries: all-ones fields, both modes
        step(1, 32'hFFFF_FFFF, 0, 1);
        step(1, 32'hFFFF_FFFF, 1, 1);
        step(1, 32'h8001_0003, 1, 1);
        step(0, '0, 0, 1);
        step(0, '0, 0, 1);
        chk(!out_valid && exp_q.size() == 0, "R8 drained",
            64'(out_valid), 64'd0);

        // R5: hold a shifted beat, flip the control, then drain
        step(1, 32'hFFFF_ABCD, 1, 0);
        step(0, '0, 0, 0);
        step(1, 32'h1234_5678, 0, 0);
        #1;
        chk(out_data == exp_main(32'hFFFF_ABCD, 1'b1), "R5 held beat",
            64'(out_data), 64'(exp_main(32'hFFFF_ABCD, 1'b1)));
        // R7: drain and refill in one cycle
        step(1, 32'h1234_5678, 0, 1);
        step(0, '0, 0, 1);
        step(0, '0, 0, 1);

        // random traffic with frequent backpressure
        for (int i = 0; i < 4000; i++) begin
            logic ordy = ($urandom_range(99) < ((i / 500) % 2 ? 30 : 80));
            step(logic'($urandom_range(3) != 0), IW'($urandom), logic'($urandom_range(1)),
                 ordy);
        end
        for (int i = 0; i < 8; i++) step(0, '0, 0, 1);
        chk(exp_q.size() == 0, "R8 all beats delivered", 64'(exp_q.size()), 64'd0);

        // R3: 18-bit samples go to 32-bit lanes
        chk($bits(w_out_data) == 64, "R3 bus width", 64'($bits(w_out_data)), 64'd64);
        for (int k = 0; k < 6; k++) begin
            logic [NC*WSW-1:0] wd = (k == 0) ? '1 : (NC*WSW)'({$urandom, $urandom});
            logic ws = logic'(k % 2);
            @(negedge clk);
            w_in_data = wd; w_shift = ws; w_in_valid = 1'b1; w_out_ready = 1'b1;
            @(negedge clk);
            w_in_valid = 1'b0;
            #1;
            chk(w_out_valid && w_out_data == exp_wide(wd, ws), "R3 wide lane",
                w_out_data, exp_wide(wd, ws));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule